// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits on the receive byte stream of an Ethernet port and decides, once per frame, whether the frame is kept or discarded. It gathers the first six bytes after a start-of-frame marker, which form the destination address. It then applies five tests in a fixed order: accept everything, accept any group address, accept the all-ones broadcast address, compare against a table of exact station addresses, and finally look the address up in a 4096-bit inexact hash table. The frame is kept if any test passes.

The host loads a control word, the exact-match table and the hash table through a write-only register port. Bytes that follow the address are not examined. Frame storage and counters are handled elsewhere. The byte gatherer is a small state machine. ST_IDLE waits for the first marker. ST_GATHER counts address bytes. ST_SKIP ignores the rest of the frame. Its transitions are: IDLE to GATHER on a marker; GATHER to GATHER on a new marker, which restarts the count; GATHER to SKIP on the sixth byte; SKIP to GATHER on a marker. After the sixth byte, a two-stage lookup pipeline produces the verdict.

Top module: `rxf_addr_filter`

## Requirements
- R1: After reset the control word is zero, every exact entry is invalid and every hash bit is clear. A frame is therefore dropped and `dec_valid` is low until a decision is made.
- R2: `dec_valid` is high for exactly one cycle, two cycles after the cycle in which the sixth address byte is presented. It is low in the cycle between. `dec_accept` carries the verdict in that same cycle.
- R3: A byte with `rx_sof` high is always byte 0 of a new address, even in the middle of gathering, and it discards any partial address. Bytes without `rx_sof` in the idle state or after the sixth byte produce no decision.
- R4: Cycles with `rx_valid` low are not counted as bytes. Address bytes may arrive with idle cycles between them.
- R5: When control bit 0 (accept-all) is set, every frame is accepted.
- R6: When control bit 1 (all-group) is set, a frame whose byte 0 has bit 0 set is accepted. A frame whose byte 0 has bit 0 clear is not accepted by this test.
- R7: When control bit 2 (broadcast) is set, a frame whose six address bytes are all 0xFF is accepted. One differing byte fails this test.
- R8: There are 16 exact entries. Entry k has its low word at register address 2k and its high word at 2k+1. Byte 0 is held in low-word bits 7:0 and byte 3 in bits 31:24. Byte 4 is held in high-word bits 7:0 and byte 5 in bits 15:8. A valid entry whose six bytes equal the address accepts the frame.
- R9: An exact entry takes part only while bit 31 of its high word is set. Bit 30 does not make an entry valid.
- R10: The hash index is ({byte5,byte4} >> s) & 0xFFF. The shift s is 4, 3, 2 or 0 for control bits 5:4 equal to 0, 1, 2 or 3.
- R11: Hash word w is at register address 0x80+w. The frame is accepted when bit (index mod 32) of word (index / 32) is set; index 0 is bit 0 of word 0 and index 4095 is bit 31 of word 127.
- R12: The control word is at register address 0x40. Writes to 0x20–0x3F and 0x41–0x7F change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| rx_valid | input | 1 | A receive byte is present |
| rx_sof | input | 1 | The present byte is the first of a frame |
| rx_data | input | 8 | Receive byte |
| dec_valid | output | 1 | One-cycle verdict strobe |
| dec_accept | output | 1 | Verdict: 1 keeps the frame, 0 drops it |

## Verification
Addresses are chosen so that each one can pass only one test. A group address with bit 0 of byte 0 set is paired with its neighbour with the bit clear. The broadcast address is paired with a copy that differs in byte 5. An exact entry is paired with an address that differs only in its last byte, which shows both the byte packing and where the compare ends. One fixed value of bytes 4 and 5 gives four different hash indices under the four shift settings, so accepting under one setting and dropping under another confirms the shift mapping. Indices 0 and 4095 pin down the word and bit order. Stream patterns with gaps, a restart in mid-address, stray bytes without a marker and trailing payload bytes show that only the six bytes after the latest marker count.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    localparam int MAC_BYTES = 6;
    localparam int CFG_AW    = 8;

    // Control word layout: bit0 accept-all, bit1 all-group, bit2 broadcast,
    // bits 5:4 hash window select.
    typedef struct packed {
        logic [1:0] hash_sel;
        logic       bcast_ok;
        logic       mcast_all;
        logic       ucast_all;
    } rxf_ctrl_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_GATHER,
        ST_SKIP
    } cap_state_e;

    function automatic logic [3:0] hash_shift(input logic [1:0] sel);
        logic [3:0] sh;
        unique case (sel)
            2'd0: sh = 4'd4;
            2'd1: sh = 4'd3;
            2'd2: sh = 4'd2;
            2'd3: sh = 4'd0;
        endcase
        return sh;
    endfunction

endpackage

// File: rtl/rxf_addr_capture.sv
module rxf_addr_capture
    import rxf_pkg::*;
#(
    parameter int NBYTES = MAC_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic [7:0]        in_data,
    output logic [NBYTES*8-1:0] addr_o,
    output logic              rdy_o
);

    localparam int CW = $clog2(NBYTES + 1);

    cap_state_e         state_q, state_d;
    logic [CW-1:0]      cnt_q;
    logic [NBYTES*8-1:0] addr_q;
    logic               rdy_q;

    logic take_sof, take_byte, last_byte;

    assign take_sof  = in_valid && in_sof;
    assign take_byte = in_valid && !in_sof && (state_q == ST_GATHER);
    assign last_byte = take_byte && (cnt_q == CW'(NBYTES - 1));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (take_sof) state_d = ST_GATHER;
            ST_GATHER: begin
                if (take_sof)       state_d = ST_GATHER;
                else if (last_byte) state_d = ST_SKIP;
            end
            ST_SKIP:   if (take_sof) state_d = ST_GATHER;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // byte counter and ready strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            rdy_q <= 1'b0;
        end else begin
            rdy_q <= last_byte;
            if (take_sof)       cnt_q <= CW'(1);
            else if (take_byte) cnt_q <= cnt_q + 1'b1;
        end
    end

    // byte lanes
    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        logic lane_we;
        if (g == 0) begin : g_first
            assign lane_we = take_sof;
        end else begin : g_rest
            assign lane_we = take_byte && (cnt_q == CW'(g));
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       addr_q[g*8 +: 8] <= 8'h00;
            else if (lane_we) addr_q[g*8 +: 8] <= in_data;
        end
    end

    assign addr_o = addr_q;
    assign rdy_o  = rdy_q;

    // R2
    rdy_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_q |=> !rdy_q);

    // R4
    rdy_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_q |-> $past(in_valid && !in_sof));

    // R3
    sof_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sof) |=> (state_q == ST_GATHER && cnt_q == CW'(1)));

endmodule

// File: rtl/rxf_exact_table.sv
module rxf_exact_table
    import rxf_pkg::*;
#(
    parameter int NUM_ENTRIES = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [$clog2(NUM_ENTRIES)-1:0] wr_entry,
    input  logic                           wr_hi,
    input  logic [31:0]                    wr_data,
    input  logic [MAC_BYTES*8-1:0]         addr_i,
    input  logic                           lookup_en,
    output logic                           hit_o
);

    localparam int EIDX_W = $clog2(NUM_ENTRIES);

    logic [NUM_ENTRIES-1:0] eq;
    logic                   hit_q;

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
        logic [31:0] lo_q;
        logic [15:0] hi_q;
        logic        vld_q;
        logic        sel;

        assign sel = wr_en && (wr_entry == EIDX_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lo_q  <= '0;
                hi_q  <= '0;
                vld_q <= 1'b0;
            end else if (sel) begin
                if (wr_hi) begin
                    hi_q  <= wr_data[15:0];
                    vld_q <= wr_data[31];
                end else begin
                    lo_q  <= wr_data;
                end
            end
        end

        assign eq[g] = vld_q && (addr_i == {hi_q, lo_q});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         hit_q <= 1'b0;
        else if (lookup_en) hit_q <= |eq;
    end

    assign hit_o = hit_q;

    // R2
    exact_hit_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hit_q) |-> $past(lookup_en));

endmodule

// File: rtl/rxf_hash_table.sv
module rxf_hash_table
    import rxf_pkg::*;
#(
    parameter int NUM_WORDS = 128,
    parameter int WORD_W    = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [$clog2(NUM_WORDS)-1:0] wr_word,
    input  logic [WORD_W-1:0]            wr_data,
    input  logic [15:0]                  key_i,
    input  logic [1:0]                   shift_sel,
    input  logic                         lookup_en,
    output logic                         hit_o
);

    localparam int IDX_W  = $clog2(NUM_WORDS * WORD_W);
    localparam int BIT_W  = $clog2(WORD_W);
    localparam int WSEL_W = $clog2(NUM_WORDS);

    logic [WORD_W-1:0] mem_q [NUM_WORDS];
    logic [IDX_W-1:0]  idx;
    logic [WSEL_W-1:0] word_sel;
    logic [BIT_W-1:0]  bit_sel;
    logic [WORD_W-1:0] word_val;
    logic              hit_q;

    assign idx      = IDX_W'(key_i >> hash_shift(shift_sel));
    assign word_sel = idx[IDX_W-1:BIT_W];
    assign bit_sel  = idx[BIT_W-1:0];
    assign word_val = mem_q[word_sel];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_WORDS; i++) mem_q[i] <= '0;
        end else if (wr_en) begin
            mem_q[wr_word] <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         hit_q <= 1'b0;
        else if (lookup_en) hit_q <= word_val[bit_sel];
    end

    assign hit_o = hit_q;

    // R11
    hash_hit_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hit_q) |-> $past(lookup_en));

endmodule

// File: rtl/rxf_addr_filter.sv
module rxf_addr_filter
    import rxf_pkg::*;
#(
    parameter int NUM_EXACT  = 16,
    parameter int HASH_WORDS = 128
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [7:0]  cfg_addr,
    input  logic [31:0] cfg_wdata,
    input  logic        rx_valid,
    input  logic        rx_sof,
    input  logic [7:0]  rx_data,
    output logic        dec_valid,
    output logic        dec_accept
);

    localparam int EIDX_W = $clog2(NUM_EXACT);
    localparam int WSEL_W = $clog2(HASH_WORDS);
    localparam logic [CFG_AW-1:0] EX_LIMIT  = CFG_AW'(2 * NUM_EXACT);
    localparam logic [CFG_AW-1:0] CTRL_ADDR = CFG_AW'(8'h40);
    localparam logic [CFG_AW-1:0] HASH_BASE = CFG_AW'(8'h80);
    localparam logic [CFG_AW:0]   HS_LIMIT  = (CFG_AW + 1)'(HASH_WORDS);

    rxf_ctrl_t              ctrl_q;
    logic [MAC_BYTES*8-1:0] addr;
    logic                   rdy;
    logic                   ex_we, hs_we;
    logic [CFG_AW-1:0]      hs_off;
    logic                   ex_hit, hs_hit;
    logic                   s1_valid_q, uc_q, mc_q, bc_q;

    // register decode
    assign ex_we  = cfg_we && (cfg_addr < EX_LIMIT);
    assign hs_off = cfg_addr - HASH_BASE;
    assign hs_we  = cfg_we && (cfg_addr >= HASH_BASE) && ({1'b0, hs_off} < HS_LIMIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (cfg_we && cfg_addr == CTRL_ADDR) begin
            ctrl_q.ucast_all <= cfg_wdata[0];
            ctrl_q.mcast_all <= cfg_wdata[1];
            ctrl_q.bcast_ok  <= cfg_wdata[2];
            ctrl_q.hash_sel  <= cfg_wdata[5:4];
        end
    end

    rxf_addr_capture #(.NBYTES(MAC_BYTES)) cap_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (rx_valid),
        .in_sof   (rx_sof),
        .in_data  (rx_data),
        .addr_o   (addr),
        .rdy_o    (rdy)
    );

    rxf_exact_table #(.NUM_ENTRIES(NUM_EXACT)) ex_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (ex_we),
        .wr_entry  (cfg_addr[EIDX_W:1]),
        .wr_hi     (cfg_addr[0]),
        .wr_data   (cfg_wdata),
        .addr_i    (addr),
        .lookup_en (rdy),
        .hit_o     (ex_hit)
    );

    rxf_hash_table #(.NUM_WORDS(HASH_WORDS), .WORD_W(32)) hs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (hs_we),
        .wr_word   (hs_off[WSEL_W-1:0]),
        .wr_data   (cfg_wdata),
        .key_i     (addr[47:32]),
        .shift_sel (ctrl_q.hash_sel),
        .lookup_en (rdy),
        .hit_o     (hs_hit)
    );

    // lookup stage: the three control-driven tests
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid_q <= 1'b0;
            uc_q       <= 1'b0;
            mc_q       <= 1'b0;
            bc_q       <= 1'b0;
        end else begin
            s1_valid_q <= rdy;
            if (rdy) begin
                uc_q <= ctrl_q.ucast_all;
                mc_q <= ctrl_q.mcast_all && addr[0];
                bc_q <= ctrl_q.bcast_ok && (&addr);
            end
        end
    end

    // verdict outputs
    always_comb begin
        dec_valid  = s1_valid_q;
        dec_accept = s1_valid_q && (uc_q || mc_q || bc_q || ex_hit || hs_hit);
    end

    // R2
    dec_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> $past(rdy));

    // R5
    ucast_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy && ctrl_q.ucast_all) |=> dec_accept);

endmodule

// File: tb/rxf_addr_filter_tb_top.sv
module rxf_addr_filter_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        rx_valid = 1'b0;
    logic        rx_sof = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        dec_valid, dec_accept;

    int nchk = 0;
    int nfail = 0;

    always #5 clk = ~clk;

    rxf_addr_filter dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .rx_valid(rx_valid), .rx_sof(rx_sof),
        .rx_data(rx_data), .dec_valid(dec_valid), .dec_accept(dec_accept)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic send_frame(input logic [47:0] da, input int gap);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_sof = (i == 0); rx_data = da[i*8 +: 8];
            if (i < 5) begin
                for (int k = 0; k < gap; k++) begin
                    @(negedge clk);
                    rx_valid = 1'b0; rx_sof = 1'b0;
                end
            end
        end
    endtask

    // verdict timing and value, sampled at negedges after the sixth byte
    task automatic judge(input logic exp, input string req);
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0;
        chk("R2 gap cycle", dec_valid, 0);
        @(negedge clk);
        chk("R2 strobe", dec_valid, 1);
        chk(req, dec_accept, exp);
        @(negedge clk);
        chk("R2 single", dec_valid, 0);
    endtask

    task automatic loose_bytes(input int n, input logic first_sof, input string req);
        int seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (dec_valid) seen++;
            rx_valid = 1'b1; rx_sof = first_sof && (i == 0); rx_data = 8'h11 * 8'(i + 1);
        end
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (dec_valid) seen++;
            rx_valid = 1'b0; rx_sof = 1'b0;
        end
        chk(req, seen, 0);
    endtask

    function automatic int hidx(input logic [15:0] key, input int sel);
        int sh;
        sh = (sel == 0) ? 4 : (sel == 1) ? 3 : (sel == 2) ? 2 : 0;
        return (int'(key) >> sh) & 12'hFFF;
    endfunction

    task automatic t_reset;
        chk("R1 reset strobe", dec_valid, 0);
        send_frame(48'hFFFF_FFFF_FFFF, 0); judge(1'b0, "R1 broadcast dropped");
        send_frame(48'h0605_0403_0201, 0); judge(1'b0, "R1 group dropped");
    endtask

    task automatic t_promisc;
        cfg_write(8'h40, 32'h1);
        send_frame(48'h1234_5678_9ABC, 0); judge(1'b1, "R5 accept-all");
        cfg_write(8'h40, 32'h2);
        send_frame(48'h6655_4433_2201, 0); judge(1'b1, "R6 group accepted");
        send_frame(48'h6655_4433_2200, 0); judge(1'b0, "R6 individual dropped");
        cfg_write(8'h40, 32'h0);
    endtask

    task automatic t_broadcast;
        cfg_write(8'h40, 32'h4);
        send_frame(48'hFFFF_FFFF_FFFF, 0); judge(1'b1, "R7 broadcast accepted");
        send_frame(48'hFEFF_FFFF_FFFF, 0); judge(1'b0, "R7 near broadcast dropped");
        cfg_write(8'h40, 32'h0);
        send_frame(48'hFFFF_FFFF_FFFF, 0); judge(1'b0, "R7 broadcast off");
    endtask

    task automatic t_exact;
        cfg_write(8'h0A, 32'h4433_2211);
        cfg_write(8'h0B, 32'h8000_6655);
        send_frame(48'h6655_4433_2211, 0); judge(1'b1, "R8 entry 5 hit");
        send_frame(48'h6755_4433_2211, 0); judge(1'b0, "R8 byte 5 differs");
        cfg_write(8'h1E, 32'hDDCC_BBAA);
        cfg_write(8'h1F, 32'h8000_0201);
        send_frame(48'h0201_DDCC_BBAA, 0); judge(1'b1, "R8 entry 15 hit");
        cfg_write(8'h0B, 32'h4000_6655);
        send_frame(48'h6655_4433_2211, 0); judge(1'b0, "R9 bit 30 not valid");
        cfg_write(8'h0B, 32'h0000_6655);
        send_frame(48'h6655_4433_2211, 0); judge(1'b0, "R9 invalid entry");
    endtask

    task automatic t_stream;
        send_frame(48'h0201_DDCC_BBAA, 2); judge(1'b1, "R4 gapped bytes");
        loose_bytes(8, 1'b0, "R3 trailing bytes no decision");
        loose_bytes(3, 1'b1, "R3 partial address no decision");
        send_frame(48'h0201_DDCC_BBAA, 0); judge(1'b1, "R3 restart on marker");
    endtask

    task automatic t_hash;
        logic [15:0] key = 16'hC35A;
        for (int s = 0; s < 4; s++) begin
            int ix = hidx(key, s);
            cfg_write(8'h80 + 8'(ix / 32), 32'h1 << (ix % 32));
            cfg_write(8'h40, 32'(s) << 4);
            send_frame({key, 32'h0403_0200}, 0); judge(1'b1, "R10 hash window");
            cfg_write(8'h40, 32'(s ^ 1) << 4);
            send_frame({key, 32'h0403_0200}, 0); judge(1'b0, "R10 other window");
            cfg_write(8'h80 + 8'(ix / 32), 32'h0);
        end
        cfg_write(8'h40, 32'h0);
        cfg_write(8'hFF, 32'h8000_0000);
        send_frame(48'hFFF0_0000_0000, 0); judge(1'b1, "R11 index 4095");
        cfg_write(8'hFF, 32'h0);
        cfg_write(8'h80, 32'h0000_0001);
        send_frame(48'h000F_0000_0000, 0); judge(1'b1, "R11 index 0");
        cfg_write(8'h80, 32'h0);
        send_frame(48'h000F_0000_0000, 0); judge(1'b0, "R11 cleared word");
    endtask

    task automatic t_unmapped;
        cfg_write(8'h20, 32'hFFFF_FFFF);
        cfg_write(8'h21, 32'hFFFF_FFFF);
        cfg_write(8'h41, 32'hFFFF_FFFF);
        cfg_write(8'h7F, 32'hFFFF_FFFF);
        send_frame(48'hFFFF_FFFF_FFFF, 0); judge(1'b0, "R12 unmapped writes");
        send_frame(48'h0605_0403_0202, 0); judge(1'b0, "R12 control untouched");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_promisc();
        t_broadcast();
        t_exact();
        t_stream();
        t_hash();
        t_unmapped();
        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule